// File: doc/BRIEF.md
# PWM-Synchronized Conversion Trigger

This block turns a free-running PWM time base into a start-of-conversion strobe for an analog-to-digital converter. It watches the time base counter value and its count direction. When the counter reaches a programmable 16-bit compare point, it records a trigger event. The events pass through a programmable postscaler, and the postscaler emits a one-cycle pulse on `trig_out`. Placing the compare point anywhere in the period lets the sample be taken at a fixed phase of the PWM waveform.

When the time base runs in continuous up/down counting, the counter crosses the compare point twice per period. A phase-select bit then picks which crossing counts: the one on the rising ramp or the one on the falling ramp. In any other counting mode every crossing counts.

Software programs the block through a byte-wide write port. The compare value is written as two halves. The high half is only staged. The staged high half and the new low half take effect together when the low half is written, so a comparison never sees a half-updated value. Writing either half also restarts the postscaler count. The block emits its pulses at all times; whether the converter acts on them is decided outside the block.

Top module: `adc_sync_trigger`

## Requirements
- R1: Write address 1 stages the high byte of the compare value without changing the active compare value. Write address 0 loads the low byte. In that same write, the active value becomes {staged high byte, low byte}, and it is used from the next cycle on.
- R2: A trigger event occurs in a cycle where `tb_count` equals the active compare value, the phase rules allow it, and the same condition was false in the previous cycle. `trig_out` reports the postscaler result of that event in the following cycle.
- R3: A counter that stays on the compare value for several cycles produces only one event. A new event needs the qualified match to drop first.
- R4: With `tb_updown_mode`=1 and phase-select=0, only matches with `tb_down`=0 (up-counting) are events.
- R5: With `tb_updown_mode`=1 and phase-select=1, only matches with `tb_down`=1 (down-counting) are events.
- R6: With `tb_updown_mode`=0, the phase-select bit and `tb_down` are ignored, and every match is an event.
- R7: Write address 2 sets control. Bit 0 is phase-select and bits 7:4 are the postscale value n. With postscale n, `trig_out` pulses for one cycle on every (n+1)-th event, giving ratios from 1:1 to 1:16.
- R8: A write to address 0 or address 1 clears the postscaler count. An event in the same cycle as that write is discarded and gives no pulse.
- R9: Changing the postscale value does not clear the running count. The next event produces a pulse if the count of events already taken is at least the new n.
- R10: After reset `trig_out` is 0, the compare value is 0, phase-select is 0, the postscale value is 0 and the postscaler count is 0. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_count | input | 16 | PWM time base counter value |
| tb_down | input | 1 | 1 while the time base counts down |
| tb_updown_mode | input | 1 | 1 when the time base runs in continuous up/down counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 compare low, 1 compare high, 2 control |
| wr_data | input | 8 | Register write data |
| trig_out | output | 1 | Postscaled one-cycle conversion trigger |

## Verification
A wrong postscaler count shows up at the port as a pulse on the wrong event: too early, too late, or missing. It becomes visible no later than the (n+1)-th event after the fault. A stuck edge-detect flag shows in one of two ways: repeated pulses while the counter dwells on the compare value, or a missing pulse on the next crossing. Both appear within one counter pass. A wrong or half-committed compare value shows as a pulse at the wrong counter value, or as no pulse, on the first crossing after the write.

// File: rtl/adc_trig_pkg.sv
// Package: shared address codes for the conversion trigger block.
// Assumes a byte-wide write port with a two-bit address.
package adc_trig_pkg;
    typedef enum logic [1:0] {
        ADDR_CMP_LO = 2'd0,
        ADDR_CMP_HI = 2'd1,
        ADDR_CTRL   = 2'd2,
        ADDR_SPARE  = 2'd3
    } trig_addr_e;
endpackage

// File: rtl/adc_trig_regs.sv
// Module: register file holding the compare value and the control fields.
// The high half is staged and commits together with the low half, so the
// compare value never holds a half-updated value. Assumes CNT_W = 2*HALF.
module adc_trig_regs #(
    parameter int CNT_W = 16,
    parameter int PS_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [CNT_W/2-1:0]   wr_data,
    output logic [CNT_W-1:0]     cmp_value,
    output logic                 cmp_wr,
    output logic                 phase_down,
    output logic [PS_W-1:0]      ps_ratio
);
    import adc_trig_pkg::*;

    localparam int HALF = CNT_W / 2;

    logic [HALF-1:0] hi_stage;
    trig_addr_e      addr;

    assign addr   = trig_addr_e'(wr_addr);
    // Purpose: flag any compare write so the postscaler restarts.
    assign cmp_wr = wr_en && (addr == ADDR_CMP_LO || addr == ADDR_CMP_HI);

    // Purpose: stage the high half and commit the full value on a low write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_stage  <= '0;
            cmp_value <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_CMP_HI)
                hi_stage <= wr_data;
            if (addr == ADDR_CMP_LO)
                cmp_value <= {hi_stage, wr_data};
        end
    end

    // Purpose: hold the phase-select bit and the postscale value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_down <= 1'b0;
            ps_ratio   <= '0;
        end else if (wr_en && addr == ADDR_CTRL) begin
            phase_down <= wr_data[0];
            ps_ratio   <= wr_data[HALF-1 -: PS_W];
        end
    end
endmodule

// File: rtl/adc_trig_match.sv
// Module: compares the time base with the compare value, applies the phase
// rule and detects the rising edge of the qualified match. Assumes the
// direction flag is valid in the same cycle as the counter value.
module adc_trig_match #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tb_count,
    input  logic             tb_down,
    input  logic             tb_updown_mode,
    input  logic [CNT_W-1:0] cmp_value,
    input  logic             phase_down,
    output logic             trig_event
);
    logic phase_ok;
    logic match_now;
    logic match_q;

    // Purpose: in up/down mode accept only the selected ramp; otherwise any.
    always_comb begin
        if (tb_updown_mode)
            phase_ok = (tb_down == phase_down);
        else
            phase_ok = 1'b1;
        match_now  = (tb_count == cmp_value) && phase_ok;
        trig_event = match_now && !match_q;
    end

    // Purpose: remember the last qualified match for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_q <= 1'b0;
        else
            match_q <= match_now;
    end
endmodule

// File: rtl/adc_trig_postscale.sv
// Module: counts trigger events and emits one pulse per (ratio+1) events.
// A compare write clears the count and drops a coinciding event. A ratio
// change applies at the next event without clearing the count.
module adc_trig_postscale #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_event,
    input  logic            clear,
    input  logic [PS_W-1:0] ratio,
    output logic            pulse
);
    logic [PS_W-1:0] ev_cnt;
    logic            last_one;

    assign last_one = (ev_cnt >= ratio);

    // Purpose: advance the event count and decide the output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_cnt <= '0;
            pulse  <= 1'b0;
        end else if (clear) begin
            ev_cnt <= '0;
            pulse  <= 1'b0;
        end else if (trig_event) begin
            pulse  <= last_one;
            ev_cnt <= last_one ? '0 : ev_cnt + 1'b1;
        end else begin
            pulse  <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_sync_trigger.sv
// Module: top of the PWM-synchronized conversion trigger. Joins the register
// file, the match detector and the postscaler. Assumes the time base and
// the converter sit outside; the pulse is always produced.
module adc_sync_trigger #(
    parameter int CNT_W = 16,
    parameter int PS_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   tb_count,
    input  logic               tb_down,
    input  logic               tb_updown_mode,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [CNT_W/2-1:0] wr_data,
    output logic               trig_out
);
    logic [CNT_W-1:0] cmp_value;
    logic             cmp_wr;
    logic             phase_down;
    logic [PS_W-1:0]  ps_ratio;
    logic             trig_event;

    adc_trig_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cmp_value  (cmp_value),
        .cmp_wr     (cmp_wr),
        .phase_down (phase_down),
        .ps_ratio   (ps_ratio)
    );

    adc_trig_match #(.CNT_W(CNT_W)) u_match (
        .clk            (clk),
        .rst_n          (rst_n),
        .tb_count       (tb_count),
        .tb_down        (tb_down),
        .tb_updown_mode (tb_updown_mode),
        .cmp_value      (cmp_value),
        .phase_down     (phase_down),
        .trig_event     (trig_event)
    );

    adc_trig_postscale #(.PS_W(PS_W)) u_ps (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_event (trig_event),
        .clear      (cmp_wr),
        .ratio      (ps_ratio),
        .pulse      (trig_out)
    );
endmodule

// File: rtl/adc_trig_checker.sv
// Module: property checker for adc_sync_trigger, attached with bind.
// Observes ports and the committed register values of the top module.
module adc_trig_checker #(
    parameter int CNT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   tb_count,
    input logic               tb_down,
    input logic               tb_updown_mode,
    input logic               wr_en,
    input logic [1:0]         wr_addr,
    input logic [CNT_W-1:0]   cmp_value,
    input logic               phase_down,
    input logic               trig_out
);
    // R1: a high-half write leaves the active compare value unchanged
    p_hi_staged_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=> $stable(cmp_value));

    // R2: every pulse follows a cycle where the counter equalled the compare value
    p_pulse_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> ($past(tb_count) == $past(cmp_value)));

    // R3: pulses are never back to back
    p_single_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);

    // R4: up-ramp selection only triggers while counting up
    p_phase_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && $past(tb_updown_mode) && !$past(phase_down)) |-> !$past(tb_down));

    // R5: down-ramp selection only triggers while counting down
    p_phase_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out && $past(tb_updown_mode) && $past(phase_down)) |-> $past(tb_down));

    // R8: a compare write is never followed by a pulse
    p_cmp_write_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 2'd0 || wr_addr == 2'd1)) |=> !trig_out);
endmodule

bind adc_sync_trigger adc_trig_checker #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tb_count       (tb_count),
    .tb_down        (tb_down),
    .tb_updown_mode (tb_updown_mode),
    .wr_en          (wr_en),
    .wr_addr        (wr_addr),
    .cmp_value      (cmp_value),
    .phase_down     (phase_down),
    .trig_out       (trig_out)
);

// File: tb/sim_adc_sync_trigger.sv
// Scoreboard bench: the driver keeps its own model of the requirements and
// queues the expected trig_out per cycle; the monitor pops and compares.
module sim_adc_sync_trigger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tb_count = 16'h1234;
    logic        tb_down = 1'b0;
    logic        tb_updown_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        trig_out;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  val;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    // model state
    logic [15:0] m_cmp = 16'd0;
    logic [7:0]  m_hold = 8'd0;
    logic        m_phase = 1'b0;
    logic [3:0]  m_ratio = 4'd0;
    logic [3:0]  m_ps = 4'd0;
    logic        m_prev = 1'b0;
    logic        m_mode = 1'b0;

    always #10 clk = ~clk;

    adc_sync_trigger u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .tb_count       (tb_count),
        .tb_down        (tb_down),
        .tb_updown_mode (tb_updown_mode),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .trig_out       (trig_out)
    );

    task automatic cyc(input logic [15:0] cnt, input logic dn,
                       input logic we, input logic [1:0] a, input logic [7:0] d,
                       input string tag);
        logic mn, ev, cw, e;
        exp_t item;
        @(negedge clk);
        tb_count = cnt; tb_down = dn; tb_updown_mode = m_mode;
        wr_en = we; wr_addr = a; wr_data = d;
        mn = (cnt == m_cmp) && (!m_mode || (m_phase ? dn : !dn));
        ev = mn && !m_prev;
        cw = we && (a == 2'd0 || a == 2'd1);
        e  = !cw && ev && (m_ps >= m_ratio);
        m_prev = mn;
        if (cw) m_ps = 4'd0;
        else if (ev) m_ps = (m_ps >= m_ratio) ? 4'd0 : m_ps + 4'd1;
        if (we && a == 2'd1) m_hold = d;
        if (we && a == 2'd0) m_cmp = {m_hold, d};
        if (we && a == 2'd2) begin m_phase = d[0]; m_ratio = d[7:4]; end
        item.val = e; item.tag = tag;
        exp_q.push_back(item);
    endtask

    task automatic idle(input logic [15:0] cnt, input logic dn, input string tag);
        cyc(cnt, dn, 1'b0, 2'd0, 8'd0, tag);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
        cyc(16'hFFFF, 1'b0, 1'b1, a, d, tag);
    endtask

    // one crossing of the compare value 0x0180
    task automatic hit(input logic dn, input string tag);
        idle(dn ? 16'h0181 : 16'h017F, dn, tag);
        idle(16'h0180, dn, tag);
        idle(dn ? 16'h017F : 16'h0181, dn, tag);
    endtask

    // monitor: compare trig_out one step after each edge
    initial begin
        exp_t got;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                got = exp_q.pop_front();
                checks++;
                if (trig_out !== got.val) begin
                    fails++;
                    $display("FAIL %s: trig_out=%b expected=%b at %0t",
                             got.tag, trig_out, got.val, $time);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (trig_out !== 1'b0) begin
            fails++;
            $display("FAIL R10: trig_out=%b expected=0 in reset", trig_out);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(16'h1234, 1'b0, "R10");
        idle(16'h0000, 1'b0, "R10");      // reset compare 0, ratio 1:1
        idle(16'h0001, 1'b0, "R10");
        wr(2'd3, 8'hF1, "R10");           // spare address ignored
        idle(16'h0000, 1'b0, "R10");
        idle(16'h0005, 1'b0, "R10");

        // R1: staged high half does not act until the low half
        wr(2'd1, 8'h01, "R1");
        idle(16'h0100, 1'b0, "R1");
        idle(16'h0000, 1'b0, "R1");
        wr(2'd0, 8'h80, "R1");
        idle(16'h0000, 1'b0, "R1");
        // R2: crossing in free mode
        hit(1'b0, "R2");
        hit(1'b1, "R2");
        // R3: dwell on the compare value
        idle(16'h017F, 1'b0, "R3");
        repeat (4) idle(16'h0180, 1'b0, "R3");
        idle(16'h0181, 1'b0, "R3");

        // R4: up/down mode, up ramp selected
        m_mode = 1'b1;
        wr(2'd2, 8'h00, "R4");
        hit(1'b0, "R4");
        hit(1'b1, "R4");
        // R5: down ramp selected
        wr(2'd2, 8'h01, "R5");
        hit(1'b0, "R5");
        hit(1'b1, "R5");
        // R6: free mode ignores phase-select and direction
        m_mode = 1'b0;
        hit(1'b0, "R6");
        hit(1'b1, "R6");

        // R7: ratio 1:3
        wr(2'd2, 8'h20, "R7");
        for (int i = 0; i < 6; i++) hit(1'b0, "R7");
        // R7: ratio 1:16
        wr(2'd2, 8'hF0, "R7");
        for (int i = 0; i < 17; i++) hit(1'b0, "R7");

        // R8: compare writes restart the count
        wr(2'd2, 8'h30, "R8");
        hit(1'b0, "R8");
        hit(1'b0, "R8");
        wr(2'd0, 8'h80, "R8");
        for (int i = 0; i < 4; i++) hit(1'b0, "R8");
        hit(1'b0, "R8");
        wr(2'd1, 8'h01, "R8");
        for (int i = 0; i < 4; i++) hit(1'b0, "R8");
        // R8: event coinciding with a compare write is dropped
        idle(16'h017F, 1'b0, "R8");
        cyc(16'h0180, 1'b0, 1'b1, 2'd0, 8'h80, "R8");
        idle(16'h0181, 1'b0, "R8");

        // R9: ratio change keeps the count
        wr(2'd2, 8'h30, "R9");
        hit(1'b0, "R9");
        hit(1'b0, "R9");
        hit(1'b0, "R9");
        wr(2'd2, 8'h10, "R9");
        hit(1'b0, "R9");
        hit(1'b0, "R9");
        hit(1'b0, "R9");
        wr(2'd2, 8'h50, "R9");
        for (int i = 0; i < 6; i++) hit(1'b0, "R9");

        repeat (3) @(posedge clk);
        #2;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule